// File: doc/BRIEF.md
# Serial Receiver with Line Status

This block turns an asynchronous serial input into data words. It uses the same line settings as the companion transmitter: a word length of five to eight bits, an optional parity bit checked in odd, even or fixed-level mode, and stop bits. A 16x oversampling strobe sets the bit timing. A start edge is confirmed at mid-bit, and each later bit is sampled in its centre. Every word that is received completely is written, with its own error tags, into a small first-in first-out buffer. The host reads that buffer through a pop strobe. The head word is always visible on the data output.

A line status byte sums up the receive side. It also passes through two empty flags that come in from the transmitter. The error flags are sticky, and a status read strobe clears them. A separate summary bit stays set for as long as any word still held in the buffer carries an error tag. A line held low for a whole frame is reported as a break rather than a framing error. It is stored as a single zero word, and the receiver then waits for the line to return high before it looks for another start bit.

Top module: `uart_rx_status`

## Requirements
- R1: Bits arrive LSB first after a low start bit. wordLen encodes 00=5, 01=6, 10=7, 11=8 data bits. Each word is stored right-justified with its upper bits zero, and rdData shows the oldest stored word. Status bit 0 is 1 exactly while the buffer holds a word, and it rises only after the stop-bit sample of a word.
- R2: If a word completes while all FIFO_DEPTH entries are occupied and no pop happens in that cycle, the new word is discarded, status bit 1 is set, and the stored words are kept unchanged.
- R3: With parityEn=1 the bit after the data is the parity bit. When paritySticky=0, parityEven=1 expects an even count of ones over data plus parity, and parityEven=0 expects an odd count. When paritySticky=1, the parity bit must be 0 if parityEven=1 and 1 if parityEven=0. A mismatch sets status bit 2 and tags the word.
- R4: If the first stop-bit sample is low and the frame is not a break, status bit 3 is set and the word is still stored with a framing tag.
- R5: If every sample from the start bit through the stop bit is low, one 0x00 word is stored with a break tag. Status bit 4 is set, and status bits 2 and 3 are not set by that frame. No further word is received until the line has gone high and a new start bit arrives.
- R6: Status bit 5 follows thrEmpty and status bit 6 follows txEmpty at all times.
- R7: Status bit 7 is 1 while at least one stored word carries a parity, framing or break tag. It returns to 0 once all such words have been popped.
- R8: A statusRd strobe clears status bits 1 to 4 in the next cycle, unless a new event sets one of them in the cycle of the strobe.
- R9: A low level that is high again at the eighth tick after it was detected is treated as a glitch, and no word is produced.
- R10: After reset the buffer is empty and status bits 0 to 4 and bit 7 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling strobe, 16 per bit time |
| rxIn | input | 1 | Serial input, idle high |
| wordLen | input | 2 | Data bits per word (00=5 ... 11=8) |
| parityEn | input | 1 | Parity bit present |
| parityEven | input | 1 | Even parity select (fixed level 0 when sticky) |
| paritySticky | input | 1 | Fixed-level parity |
| thrEmpty | input | 1 | Transmit holding empty, shown in status bit 5 |
| txEmpty | input | 1 | Transmitter idle, shown in status bit 6 |
| popReq | input | 1 | Removes the head word |
| statusRd | input | 1 | Status read strobe, clears bits 1 to 4 |
| rdData | output | 8 | Head word of the receive buffer |
| lineStatus | output | 8 | Line status byte |

## Verification
The input passes two synchronizer flops, and the receiver samples the stop bit eight ticks into it. Data-ready, the error flags and the summary bit are registered one clock after that sample, so they are due well before the stop bit ends. The bench compares them only after a further idle gap of dozens of ticks. The effect of a status read or a pop is due on the next clock, and the bench samples it on the falling edge after the strobe has been dropped. Sticky flags, buffer order and the data-ready level are therefore always read when they are settled. Random frames with random settings and injected parity or stop faults are checked against bench functions. Directed cases cover overrun, break followed by a normal word, and a start glitch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BRKWAIT
  } rxState_t;

  typedef struct packed {
    logic clrFrame;
    logic shiftBit;
    logic capParity;
    logic endFrame;
  } rxStrobes_t;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxBit,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       lineBreak,
  output rxStrobes_t strb
);

  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rxState_t         state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [2:0]       bitIdx, idxN;
  logic [2:0]       lastIdx;

  assign lastIdx = 3'(wordLen) + 3'd4;

  always_comb begin
    strb   = '0;
    stateN = state;
    cntN   = cnt;
    idxN   = bitIdx;
    case (state)
      ST_IDLE: begin
        if (tick16 && !rxBit) begin
          stateN = ST_START;
          cntN   = '0;
        end
      end
      ST_START: begin
        if (tick16) begin
          if (cnt == MID) begin
            if (rxBit) begin
              stateN = ST_IDLE;
            end else begin
              stateN        = ST_DATA;
              cntN          = '0;
              idxN          = '0;
              strb.clrFrame = 1'b1;
            end
          end else begin
            cntN = cnt + CNT_W'(1);
          end
        end
      end
      ST_DATA: begin
        if (tick16) begin
          cntN = cnt + CNT_W'(1);
          if (cnt == LAST) begin
            strb.shiftBit = 1'b1;
            idxN          = bitIdx + 3'd1;
            if (bitIdx == lastIdx) stateN = parityEn ? ST_PARITY : ST_STOP;
          end
        end
      end
      ST_PARITY: begin
        if (tick16) begin
          cntN = cnt + CNT_W'(1);
          if (cnt == LAST) begin
            strb.capParity = 1'b1;
            stateN         = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (tick16) begin
          cntN = cnt + CNT_W'(1);
          if (cnt == LAST) begin
            strb.endFrame = 1'b1;
            stateN        = lineBreak ? ST_BRKWAIT : ST_IDLE;
          end
        end
      end
      ST_BRKWAIT: begin
        if (rxBit) stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateN;
      cnt    <= cntN;
      bitIdx <= idxN;
    end
  end

  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && tick16 && cnt == MID && rxBit) |=> (state == ST_IDLE)); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R1

  AST_BRK_WAITS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BRKWAIT && !rxBit) |=> (state == ST_BRKWAIT)); // R5

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strb,
  input  logic              rxBit,
  input  logic [1:0]        wordLen,
  input  logic              parityEn,
  input  logic              parityEven,
  input  logic              paritySticky,
  input  logic              popReq,
  input  logic              statusRd,
  input  logic              thrEmpty,
  input  logic              txEmpty,
  output logic              lineBreak,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        lineStatus
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic [DATA_W-1:0] alignedData;
  logic              expParity;
  rxEntry_t          newEntry;

  rxEntry_t          mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count, errCount;
  rxEntry_t          head;
  logic              popFire, pushOk, overrunEv, newErr, headErr;
  logic              oeFlag, peFlag, feFlag, biFlag;

  // frame assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strb.clrFrame) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strb.shiftBit)  shiftReg <= {rxBit, shiftReg[DATA_W-1:1]};
      if (strb.capParity) parBit   <= rxBit;
    end
  end

  assign alignedData = shiftReg >> (2'd3 - wordLen);
  assign expParity   = paritySticky ? ~parityEven
                                    : (parityEven ? ^alignedData : ~^alignedData);
  assign lineBreak   = (shiftReg == '0) && !parBit && !rxBit;

  always_comb begin
    newEntry.data = alignedData;
    newEntry.brk  = lineBreak;
    newEntry.fe   = !rxBit && !lineBreak;
    newEntry.pe   = parityEn && (parBit != expParity) && !lineBreak;
  end

  // receive buffer
  assign head      = mem[rdPtr];
  assign popFire   = popReq && (count != '0);
  assign pushOk    = strb.endFrame && ((count != FULL_CNT) || popFire);
  assign overrunEv = strb.endFrame && !pushOk;
  assign newErr    = newEntry.brk | newEntry.fe | newEntry.pe;
  assign headErr   = head.brk | head.fe | head.pe;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      errCount <= '0;
    end else begin
      if (pushOk)  wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (popFire) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      case ({pushOk, popFire})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      case ({pushOk && newErr, popFire && headErr})
        2'b10:   errCount <= errCount + CNT_W'(1);
        2'b01:   errCount <= errCount - CNT_W'(1);
        default: errCount <= errCount;
      endcase
    end
  end

  // sticky status flags, set wins over read-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeFlag <= 1'b0;
      peFlag <= 1'b0;
      feFlag <= 1'b0;
      biFlag <= 1'b0;
    end else begin
      oeFlag <= overrunEv                | (oeFlag && !statusRd);
      peFlag <= (pushOk && newEntry.pe)  | (peFlag && !statusRd);
      feFlag <= (pushOk && newEntry.fe)  | (feFlag && !statusRd);
      biFlag <= (pushOk && newEntry.brk) | (biFlag && !statusRd);
    end
  end

  assign rdData     = (count != '0) ? head.data : '0;
  assign lineStatus = {(errCount != '0), txEmpty, thrEmpty,
                       biFlag, feFlag, peFlag, oeFlag, (count != '0)};

  AST_DR_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.endFrame && count == '0) |=> lineStatus[0]); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.endFrame && count == FULL_CNT && !popReq) |=> (count == FULL_CNT) && lineStatus[1]); // R2

  AST_BRK_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.endFrame && lineBreak && count != FULL_CNT) |=> lineStatus[4] && lineStatus[7]); // R5

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= count); // R7

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strb.endFrame) |=> (lineStatus[4:1] == 4'b0000)); // R8

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxIn,
  input  logic [1:0] wordLen,
  input  logic       parityEn,
  input  logic       parityEven,
  input  logic       paritySticky,
  input  logic       thrEmpty,
  input  logic       txEmpty,
  input  logic       popReq,
  input  logic       statusRd,
  output logic [7:0] rdData,
  output logic [7:0] lineStatus
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxBit;
  logic                   lineBreak;
  rxStrobes_t             strb;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
      end
    end else begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxIn;
      end
    end
  endgenerate

  assign rxBit = syncQ[SYNC_STAGES-1];

  uart_rx_ctrl #(.OSR(OSR)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick16    (tick16),
    .rxBit     (rxBit),
    .wordLen   (wordLen),
    .parityEn  (parityEn),
    .lineBreak (lineBreak),
    .strb      (strb)
  );

  uart_rx_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .rxBit        (rxBit),
    .wordLen      (wordLen),
    .parityEn     (parityEn),
    .parityEven   (parityEven),
    .paritySticky (paritySticky),
    .popReq       (popReq),
    .statusRd     (statusRd),
    .thrEmpty     (thrEmpty),
    .txEmpty      (txEmpty),
    .lineBreak    (lineBreak),
    .rdData       (rdData),
    .lineStatus   (lineStatus)
  );

endmodule

// File: tb/tb_uart_rx_status.sv
`timescale 1ns/1ps
module tb_uart_rx_status;

  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxIn = 1'b1;
  logic [1:0] wordLen = 2'd3;
  logic       parityEn = 1'b0, parityEven = 1'b0, paritySticky = 1'b0;
  logic       thrEmpty = 1'b1, txEmpty = 1'b1;
  logic       popReq = 1'b0, statusRd = 1'b0;
  logic [7:0] rdData, lineStatus;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int tickDiv = 0;

  uart_rx_status #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxIn(rxIn),
    .wordLen(wordLen), .parityEn(parityEn), .parityEven(parityEven),
    .paritySticky(paritySticky), .thrEmpty(thrEmpty), .txEmpty(txEmpty),
    .popReq(popReq), .statusRd(statusRd), .rdData(rdData), .lineStatus(lineStatus)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
    tick16  <= (tickDiv == 3);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000 cycles", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic expParity(input logic [7:0] d, input logic even, input logic stick);
    if (stick) return ~even;
    return even ? ^d : ~^d;
  endfunction

  function automatic logic [7:0] wordMask(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

  function automatic logic [7:0] expStatus(input logic dr, input logic oe, input logic pe,
                                           input logic fe, input logic bi, input logic sum);
    return {sum, txEmpty, thrEmpty, bi, fe, pe, oe, dr};
  endfunction

  task automatic checkVal(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitTick();
    do @(posedge clk); while (!tick16);
  endtask

  task automatic driveBit(input logic v, input int nTicks);
    @(negedge clk) rxIn = v;
    repeat (nTicks) waitTick();
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic badPar, input logic badStop);
    int n = int'(wordLen) + 5;
    driveBit(1'b0, 16);
    for (int i = 0; i < n; i++) driveBit(d[i], 16);
    if (parityEn) driveBit(expParity(d & wordMask(wordLen), parityEven, paritySticky) ^ badPar, 16);
    if (badStop) begin
      driveBit(1'b0, 9);
      driveBit(1'b1, 32);
    end else begin
      driveBit(1'b1, 40);
    end
  endtask

  task automatic pulseRead();
    @(negedge clk) statusRd = 1'b1;
    @(negedge clk) statusRd = 1'b0;
  endtask

  task automatic pulsePop();
    @(negedge clk) popReq = 1'b1;
    @(negedge clk) popReq = 1'b0;
  endtask

  initial begin
    logic [7:0] d, m, dq [DEPTH+1];
    logic bp, bs, expPe;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state, R6 pass-through
    checkVal("R10 reset status", lineStatus, expStatus(0, 0, 0, 0, 0, 0));
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    thrEmpty = 1'b0; txEmpty = 1'b1;
    @(negedge clk);
    checkVal("R6 empty flags mirror", lineStatus, expStatus(0, 0, 0, 0, 0, 0));

    // random frames with random settings and injected faults: R1 R3 R4 R6 R7 R8
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      wordLen      = 2'($urandom % 4);
      parityEn     = 1'($urandom % 2);
      parityEven   = 1'($urandom % 2);
      paritySticky = 1'($urandom % 2);
      thrEmpty     = 1'($urandom % 2);
      txEmpty      = 1'($urandom % 2);
      bp = parityEn && ($urandom % 4 == 0);
      bs = ($urandom % 5 == 0);
      m  = wordMask(wordLen);
      d  = 8'($urandom) & m;
      if (bs && d == 8'h00) d = 8'h01;
      sendFrame(d, bp, bs);
      expPe = bp;
      checkVal("R1/R3/R4/R7 status after word", lineStatus, expStatus(1, 0, expPe, bs, 0, expPe | bs));
      checkVal("R1 received data", rdData, d);
      pulseRead();
      pulsePop();
      checkVal("R8 flags cleared after read and pop", lineStatus, expStatus(0, 0, 0, 0, 0, 0));
    end

    // R3 directed: fixed-level parity, level 1 expected when parityEven=0
    @(negedge clk);
    wordLen = 2'd3; parityEn = 1'b1; parityEven = 1'b0; paritySticky = 1'b1;
    sendFrame(8'h3C, 1'b1, 1'b0);
    checkVal("R3 sticky parity mismatch", lineStatus, expStatus(1, 0, 1, 0, 0, 1));
    pulseRead();
    pulsePop();

    // R2 overrun: DEPTH+1 words with no pop
    @(negedge clk);
    wordLen = 2'd3; parityEn = 1'b0;
    for (int k = 0; k <= DEPTH; k++) begin
      dq[k] = 8'($urandom);
      sendFrame(dq[k], 1'b0, 1'b0);
    end
    checkVal("R2 overrun flagged", lineStatus, expStatus(1, 1, 0, 0, 0, 0));
    pulseRead();
    checkVal("R8 overrun cleared by read", lineStatus, expStatus(1, 0, 0, 0, 0, 0));
    for (int k = 0; k < DEPTH; k++) begin
      checkVal("R2 stored words kept in order", rdData, dq[k]);
      pulsePop();
    end
    checkVal("R2 newest word discarded", lineStatus, expStatus(0, 0, 0, 0, 0, 0));

    // R5 break then a normal word
    driveBit(1'b0, 16 * 13);
    driveBit(1'b1, 32);
    checkVal("R5 break status", lineStatus, expStatus(1, 0, 0, 0, 1, 1));
    checkVal("R5 break word is zero", rdData, 8'h00);
    sendFrame(8'hA5, 1'b0, 1'b0);
    pulseRead();
    checkVal("R7 summary held while break word stored", lineStatus, expStatus(1, 0, 0, 0, 0, 1));
    pulsePop();
    checkVal("R5 single word then next frame", rdData, 8'hA5);
    checkVal("R7 summary drops after pop", lineStatus, expStatus(1, 0, 0, 0, 0, 0));
    pulsePop();

    // R9 start glitch
    driveBit(1'b0, 5);
    driveBit(1'b1, 48);
    checkVal("R9 glitch produces no word", lineStatus, expStatus(0, 0, 0, 0, 0, 0));

    // R1 five-bit word with upper bits zero
    @(negedge clk);
    wordLen = 2'd0;
    sendFrame(8'hFF, 1'b0, 1'b0);
    checkVal("R1 five-bit right justified", rdData, 8'h1F);
    pulsePop();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule